// File: doc/BRIEF.md
# PHY Power-Up Sequencer

This block brings a serial display PHY out of reset in a fixed order once software asks for it. A one-cycle `start_i` request captures the lane configuration and runs a short preparation phase. The four PHY control lines are held inactive while the test-clear line is pulsed. All four lines are then raised together, and the sequencer waits in turn for the PLL to report lock and for the clock lane to report its stop state.

Each wait has its own bounded window, counted in system clock cycles. When a window expires, the sequencer sets a sticky warning flag for that wait and moves on. It does not abort. The done flag therefore rises after both waits whatever their outcome, and the controlling software reads the two flags to decide whether the bring-up was clean. A new request from the idle or done state restarts the whole sequence and clears the flags. A request made while the sequence is in progress is ignored.

The lane count is presented to the PHY as a 2-bit code (lanes minus one), next to an 8-bit stop-wait time. Both are captured when a request is accepted.

Top module: `dphy_pwrup_seq`

## Requirements
- R1: While and after reset, with no request yet accepted, `phy_ctrl_o` is 0, `test_clr_o`, `busy_o`, `done_o`, `lock_to_o` and `stop_to_o` are 0, and `lane_code_o` and `stop_wait_o` are 0.
- R2: `phy_ctrl_o` bit 0 releases shutdown, bit 1 releases reset, bit 2 enables the clock and bit 3 forces the PLL on. The vector is always either 4'h0 (all inactive) or 4'hF (all active), and it is 4'h0 from the cycle after a request until enable.
- R3: After an accepted request, `test_clr_o` is low for one cycle, then high for `TCLR_CYC` cycles, then low for one cycle. `phy_ctrl_o` becomes 4'hF in the cycle after that, `TCLR_CYC`+2 cycles after the request edge.
- R4: The lock wait comes first. If the stop-state input is already high during the lock wait, it has no effect, and the stop wait ends on the first clock after the lock wait ends.
- R5: If `pll_lock_i` is not sampled high within `TIMEOUT_CYC` cycles of enable, `lock_to_o` is set and the stop wait starts. If lock is sampled on the last cycle of the window, no timeout is flagged.
- R6: If `clk_stop_i` is not sampled high within `TIMEOUT_CYC` cycles of the start of the stop wait, `stop_to_o` is set and the sequence completes anyway.
- R7: `done_o` rises when the stop wait ends, whether or not either wait timed out. `done_o`, both timeout flags and `phy_ctrl_o` = 4'hF then hold until the next accepted request.
- R8: `start_i` is ignored while `busy_o` is high. The completion time and the flags are unchanged.
- R9: A request made while `done_o` is high restarts the sequence. In the cycle after that request edge, `done_o`, `lock_to_o` and `stop_to_o` are 0.
- R10: On acceptance, `lane_code_o` = (`lanes_i` − 1) mod 4 and `stop_wait_o` = `stop_wait_i`. Both hold until the next accepted request, regardless of later input changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Bring-up request, one cycle |
| lanes_i | input | 3 | Number of data lanes, 1 to 4 |
| stop_wait_i | input | 8 | Stop-wait time to hand to the PHY |
| pll_lock_i | input | 1 | PLL lock status from the PHY |
| clk_stop_i | input | 1 | Clock lane stop-state status from the PHY |
| phy_ctrl_o | output | 4 | {PLL force, clock enable, reset release, shutdown release} |
| test_clr_o | output | 1 | PHY test-clear line |
| lane_code_o | output | 2 | Lanes minus one |
| stop_wait_o | output | 8 | Captured stop-wait time |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Both waits finished |
| lock_to_o | output | 1 | Sticky: lock wait timed out |
| stop_to_o | output | 1 | Sticky: stop-state wait timed out |

## Verification
The checker enforces these properties on every cycle:
- the control vector is all-or-nothing;
- the test-clear line is never high while the PHY is enabled;
- enable is preceded by a low test-clear cycle;
- a timeout flag rises only when the awaited input was low;
- done and the flags hold while no request arrives;
- the captured configuration is stable while busy.

Some behaviour only the bench scenarios can show: the exact completion cycle for a given pair of PHY response delays, the boundary where lock arrives on the last cycle of the window, and that an early stop state is ignored during the lock wait. The same holds for a request during busy leaving the timing untouched, and for the restart clearing the flags.

// File: rtl/dps_pkg.sv
package dps_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_INIT  = 3'd1,
      ST_TCLR  = 3'd2,
      ST_TREL  = 3'd3,
      ST_WLOCK = 3'd4,
      ST_WSTOP = 3'd5,
      ST_DONE  = 3'd6
   } seq_st_e;

   // bit positions in the PHY control vector (decoded by the PHY)
   localparam int CTL_SHUT_REL = 0;
   localparam int CTL_RST_REL  = 1;
   localparam int CTL_CLK_EN   = 2;
   localparam int CTL_PLL_FRC  = 3;
   localparam int CTL_W        = 4;

endpackage

// File: rtl/dps_wait_timer.sv
module dps_wait_timer #(
   parameter int TMO_CYC   = 64,
   parameter int PULSE_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic run_i,
   output logic tmo_hit_o,
   output logic pulse_hit_o
);
   localparam int MAXV  = (TMO_CYC > PULSE_CYC) ? TMO_CYC : PULSE_CYC;
   localparam int CNT_W = $clog2(MAXV + 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (clr_i || !run_i) cnt_q <= '0;
      else if (cnt_q != CNT_W'(MAXV)) cnt_q <= cnt_q + CNT_W'(1);
   end

   assign tmo_hit_o   = (cnt_q == CNT_W'(TMO_CYC - 1));
   assign pulse_hit_o = (cnt_q == CNT_W'(PULSE_CYC - 1));
endmodule

// File: rtl/dps_cfg_hold.sv
module dps_cfg_hold #(
   parameter int LANE_W  = 3,
   parameter int CODE_W  = 2,
   parameter int SWAIT_W = 8,
   parameter bit LATCH   = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               capture_i,
   input  logic [LANE_W-1:0]  lanes_i,
   input  logic [SWAIT_W-1:0] stop_wait_i,
   output logic [CODE_W-1:0]  lane_code_o,
   output logic [SWAIT_W-1:0] stop_wait_o
);
   logic [CODE_W-1:0] code_now;
   assign code_now = CODE_W'(lanes_i - LANE_W'(1));

   generate
      if (LATCH) begin : g_latched
         logic [CODE_W-1:0]  code_q;
         logic [SWAIT_W-1:0] sw_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               code_q <= '0;
               sw_q   <= '0;
            end else if (capture_i) begin
               code_q <= code_now;
               sw_q   <= stop_wait_i;
            end
         end
         assign lane_code_o = code_q;
         assign stop_wait_o = sw_q;
      end else begin : g_direct
         assign lane_code_o = code_now;
         assign stop_wait_o = stop_wait_i;
      end
   endgenerate
endmodule

// File: rtl/dphy_pwrup_seq.sv
module dphy_pwrup_seq
   import dps_pkg::*;
#(
   parameter int TIMEOUT_CYC = 64,
   parameter int TCLR_CYC    = 2,
   parameter int LANE_W      = 3,
   parameter int CODE_W      = 2,
   parameter int SWAIT_W     = 8,
   parameter bit LATCH_CFG   = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [LANE_W-1:0]  lanes_i,
   input  logic [SWAIT_W-1:0] stop_wait_i,
   input  logic               pll_lock_i,
   input  logic               clk_stop_i,
   output logic [CTL_W-1:0]   phy_ctrl_o,
   output logic               test_clr_o,
   output logic [CODE_W-1:0]  lane_code_o,
   output logic [SWAIT_W-1:0] stop_wait_o,
   output logic               busy_o,
   output logic               done_o,
   output logic               lock_to_o,
   output logic               stop_to_o
);

   generate
      if (TIMEOUT_CYC < 2) begin : g_chk_tmo
         $error("TIMEOUT_CYC must be at least 2");
      end
      if (TCLR_CYC < 1) begin : g_chk_tclr
         $error("TCLR_CYC must be at least 1");
      end
      if (LANE_W < CODE_W + 1) begin : g_chk_lane
         $error("LANE_W must hold a count of 2**CODE_W lanes");
      end
   endgenerate

   seq_st_e st_q, st_d;
   logic    accept, tmo_hit, pulse_hit, tmr_run, enabled;
   logic    lock_to_q, stop_to_q;

   assign accept = start_i && (st_q == ST_IDLE || st_q == ST_DONE);

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE, ST_DONE: if (start_i) st_d = ST_INIT;
         ST_INIT:          st_d = ST_TCLR;
         ST_TCLR:          if (pulse_hit) st_d = ST_TREL;
         ST_TREL:          st_d = ST_WLOCK;
         ST_WLOCK:         if (pll_lock_i || tmo_hit) st_d = ST_WSTOP;
         ST_WSTOP:         if (clk_stop_i || tmo_hit) st_d = ST_DONE;
         default:          st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   assign tmr_run = (st_q == ST_TCLR) || (st_q == ST_WLOCK) || (st_q == ST_WSTOP);

   dps_wait_timer #(
      .TMO_CYC   (TIMEOUT_CYC),
      .PULSE_CYC (TCLR_CYC)
   ) u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr_i       (st_d != st_q),
      .run_i       (tmr_run),
      .tmo_hit_o   (tmo_hit),
      .pulse_hit_o (pulse_hit)
   );

   dps_cfg_hold #(
      .LANE_W  (LANE_W),
      .CODE_W  (CODE_W),
      .SWAIT_W (SWAIT_W),
      .LATCH   (LATCH_CFG)
   ) u_cfg (
      .clk         (clk),
      .rst_n       (rst_n),
      .capture_i   (accept),
      .lanes_i     (lanes_i),
      .stop_wait_i (stop_wait_i),
      .lane_code_o (lane_code_o),
      .stop_wait_o (stop_wait_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_to_q <= 1'b0;
         stop_to_q <= 1'b0;
      end else if (accept) begin
         lock_to_q <= 1'b0;
         stop_to_q <= 1'b0;
      end else begin
         if (st_q == ST_WLOCK && !pll_lock_i && tmo_hit) lock_to_q <= 1'b1;
         if (st_q == ST_WSTOP && !clk_stop_i && tmo_hit) stop_to_q <= 1'b1;
      end
   end

   assign enabled = (st_q == ST_WLOCK) || (st_q == ST_WSTOP) || (st_q == ST_DONE);

   always_comb begin
      phy_ctrl_o               = '0;
      phy_ctrl_o[CTL_SHUT_REL] = enabled;
      phy_ctrl_o[CTL_RST_REL]  = enabled;
      phy_ctrl_o[CTL_CLK_EN]   = enabled;
      phy_ctrl_o[CTL_PLL_FRC]  = enabled;
   end

   assign test_clr_o = (st_q == ST_TCLR);
   assign busy_o     = (st_q != ST_IDLE) && (st_q != ST_DONE);
   assign done_o     = (st_q == ST_DONE);
   assign lock_to_o  = lock_to_q;
   assign stop_to_o  = stop_to_q;

endmodule

// File: rtl/dps_checker.sv
module dps_checker #(
   parameter int CODE_W  = 2,
   parameter int SWAIT_W = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               start_i,
   input logic               pll_lock_i,
   input logic               clk_stop_i,
   input logic [3:0]         phy_ctrl_o,
   input logic               test_clr_o,
   input logic [CODE_W-1:0]  lane_code_o,
   input logic [SWAIT_W-1:0] stop_wait_o,
   input logic               busy_o,
   input logic               done_o,
   input logic               lock_to_o,
   input logic               stop_to_o
);

   p_ctrl_all_or_none_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (phy_ctrl_o == 4'h0) || (phy_ctrl_o == 4'hF));

   p_tclr_while_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
      test_clr_o |-> (phy_ctrl_o == 4'h0));

   p_low_before_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (phy_ctrl_o == 4'hF && $past(phy_ctrl_o) == 4'h0) |-> !$past(test_clr_o));

   p_lock_tmo_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_to_o) |-> !$past(pll_lock_i));

   p_stop_tmo_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stop_to_o) |-> !$past(clk_stop_i));

   p_done_enabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (phy_ctrl_o == 4'hF) && !busy_o);

   p_done_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> done_o && $stable(lock_to_o) && $stable(stop_to_o));

   p_cfg_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> $stable(lane_code_o) && $stable(stop_wait_o));

endmodule

bind dphy_pwrup_seq dps_checker #(.CODE_W(CODE_W), .SWAIT_W(SWAIT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .pll_lock_i  (pll_lock_i),
   .clk_stop_i  (clk_stop_i),
   .phy_ctrl_o  (phy_ctrl_o),
   .test_clr_o  (test_clr_o),
   .lane_code_o (lane_code_o),
   .stop_wait_o (stop_wait_o),
   .busy_o      (busy_o),
   .done_o      (done_o),
   .lock_to_o   (lock_to_o),
   .stop_to_o   (stop_to_o)
);

// File: tb/tb_dphy_pwrup_seq.sv
module tb_dphy_pwrup_seq;
   localparam int T  = 64;
   localparam int PL = 2;
   localparam int W  = PL + 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic [2:0] lanes_i = 3'd1;
   logic [7:0] stop_wait_i = 8'd0;
   logic       pll_lock_i = 1'b0;
   logic       clk_stop_i = 1'b0;
   logic [3:0] phy_ctrl_o;
   logic       test_clr_o;
   logic [1:0] lane_code_o;
   logic [7:0] stop_wait_o;
   logic       busy_o, done_o, lock_to_o, stop_to_o;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   dphy_pwrup_seq #(.TIMEOUT_CYC(T), .TCLR_CYC(PL)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .lanes_i(lanes_i),
      .stop_wait_i(stop_wait_i), .pll_lock_i(pll_lock_i), .clk_stop_i(clk_stop_i),
      .phy_ctrl_o(phy_ctrl_o), .test_clr_o(test_clr_o), .lane_code_o(lane_code_o),
      .stop_wait_o(stop_wait_o), .busy_o(busy_o), .done_o(done_o),
      .lock_to_o(lock_to_o), .stop_to_o(stop_to_o));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // expected completion cycle and flags from the requirements
   function automatic void predict(input int dl, input int ds,
                                   output int s, output bit lto, output bit sto);
      int a, l, cand;
      a    = (dl + 1 < T) ? dl + 1 : T;
      lto  = (dl + 1 > T);
      l    = W + a;
      cand = (l + 1 > W + ds + 1) ? l + 1 : W + ds + 1;
      if (cand <= l + T) begin s = cand; sto = 1'b0; end
      else begin s = l + T; sto = 1'b1; end
   endfunction

   task automatic run_seq(input int dl, input int ds, input int lanes,
                          input int sw, input bit poke, input string tag);
      int  f = -1, t_first = -1, t_cnt = 0, s_meas = -1, s_exp;
      bit  lto, sto, ctrl_bad = 1'b0;
      logic [1:0] code_exp;
      code_exp = 2'(lanes - 1);
      predict(dl, ds, s_exp, lto, sto);
      @(negedge clk);
      pll_lock_i = 1'b0; clk_stop_i = 1'b0;
      start_i = 1'b1; lanes_i = 3'(lanes); stop_wait_i = 8'(sw);
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      for (int n = 0; n < 400; n++) begin
         if (n == 0) begin
            check(!done_o && !lock_to_o && !stop_to_o, {tag, " R9 flags cleared"},
                  {done_o, lock_to_o, stop_to_o}, 0);
            check(phy_ctrl_o == 4'h0, {tag, " R2 init inactive"}, phy_ctrl_o, 0);
         end
         if (test_clr_o) begin
            if (t_first < 0) t_first = n;
            t_cnt++;
         end
         if (f < 0 && phy_ctrl_o == 4'hF) f = n;
         if ((f < 0 && phy_ctrl_o != 4'h0) || (f >= 0 && phy_ctrl_o != 4'hF)) ctrl_bad = 1'b1;
         if (done_o) begin s_meas = n; break; end
         if (f >= 0) begin
            pll_lock_i = (n >= f + dl);
            clk_stop_i = (n >= f + ds);
         end
         if (n == 2) begin lanes_i = ~lanes_i; stop_wait_i = ~stop_wait_i; end
         if (poke && n == W + 1) start_i = 1'b1;
         if (poke && n == W + 2) start_i = 1'b0;
         @(negedge clk);
      end
      start_i = 1'b0;
      check(t_first == 1, {tag, " R3 test-clear start"}, t_first, 1);
      check(t_cnt == PL, {tag, " R3 test-clear length"}, t_cnt, PL);
      check(f == W, {tag, " R3 enable cycle"}, f, W);
      check(!ctrl_bad, {tag, " R2 control vector"}, ctrl_bad, 0);
      check(s_meas == s_exp, {tag, poke ? " R8" : " R4", " done cycle"}, s_meas, s_exp);
      check(lock_to_o == lto, {tag, " R5 lock timeout"}, lock_to_o, lto);
      check(stop_to_o == sto, {tag, " R6 stop timeout"}, stop_to_o, sto);
      check(lane_code_o == code_exp, {tag, " R10 lane code"}, lane_code_o, code_exp);
      check(stop_wait_o == 8'(sw), {tag, " R10 stop wait"}, stop_wait_o, sw);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         pll_lock_i = ~pll_lock_i;
         clk_stop_i = ~clk_stop_i;
         check(done_o && phy_ctrl_o == 4'hF && lock_to_o == lto && stop_to_o == sto,
               {tag, " R7 done holds"}, {done_o, phy_ctrl_o, lock_to_o, stop_to_o},
               {1'b1, 4'hF, lto, sto});
      end
   endtask

   initial begin
      void'($urandom(32'd7391));
      repeat (3) @(negedge clk);
      check(phy_ctrl_o == 4'h0 && !test_clr_o && !busy_o && !done_o,
            "R1 in reset", {phy_ctrl_o, test_clr_o, busy_o, done_o}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(phy_ctrl_o == 4'h0 && !test_clr_o && !busy_o && !done_o &&
            !lock_to_o && !stop_to_o && lane_code_o == 2'd0 && stop_wait_o == 8'd0,
            "R1 after reset", {phy_ctrl_o, busy_o, done_o, lock_to_o, stop_to_o}, 0);

      run_seq(3, 5, 4, 8'h20, 1'b0, "fast");
      run_seq(10, 0, 1, 8'h11, 1'b0, "early-stop");
      run_seq(T + 20, 5, 2, 8'h7e, 1'b0, "lock-tmo");
      run_seq(2, T + 50, 3, 8'h05, 1'b0, "stop-tmo");
      run_seq(T + 5, 3 * T, 4, 8'hff, 1'b0, "both-tmo");
      run_seq(T - 1, T - 1, 1, 8'h40, 1'b0, "lock-edge");
      run_seq(T, T, 2, 8'h41, 1'b0, "lock-late");
      run_seq(0, 0, 3, 8'h33, 1'b0, "instant");
      run_seq(6, 9, 2, 8'h99, 1'b1, "poke");
      for (int i = 0; i < 8; i++) begin
         run_seq($urandom_range(0, T + 10), $urandom_range(0, 2 * T + 10),
                 $urandom_range(1, 4), $urandom_range(0, 255),
                 1'($urandom_range(0, 1)), "rand");
      end
      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end
endmodule